// File: doc/BRIEF.md
# Video Lock Status Filter

This block sits behind the sync recovery path of a video decoder and turns noisy, per-line lock indications into steady status flags. Once per video line a strobe arrives. With each strobe the block takes one sample of the horizontal lock source that a select input picks, and one sample of the subcarrier lock indication. Hysteresis counters then decide when lock is gained and when it is lost. A lock flag rises only after a programmable run of consecutive locked lines. It falls only after a separate programmable run of consecutive unlocked lines.

There are two filtered results. The horizontal result uses the selected horizontal source alone. The overall result uses the same source, optionally gated by subcarrier lock. A one-cycle change pulse goes to an interrupt block whenever the overall flag changes state. All state moves only on strobed cycles of a single clock.

Top module: `vlock_filter`

## Requirements
- R1: After reset, `lock_all`, `lock_h`, `lock_sc` and `lock_chg` are all 0, and both run counters start from zero.
- R2: With `src_sel`=0 the horizontal sample is `hlock_a` and `hlock_b` has no effect. With `src_sel`=1 the horizontal sample is `hlock_b` and `hlock_a` has no effect.
- R3: While a filtered flag is 0, it becomes 1 in the cycle after the strobe that completes N consecutive strobed samples of 1. N is the threshold of `in_code`: code 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→`LONG_THR`.
- R4: While a filtered flag is 1, it becomes 0 in the cycle after the strobe that completes N consecutive strobed samples of 0. N comes from `out_code` with the same code table.
- R5: A strobed sample equal to the current flag value restarts the run toward the opposite state from zero.
- R6: With `sc_incl`=0, the overall flag is filtered from the horizontal sample alone, and `sc_lock` has no effect on it.
- R7: With `sc_incl`=1, the overall sample is the horizontal sample AND `sc_lock`. A strobe with `sc_lock`=0 therefore counts as unlocked for the overall flag.
- R8: `lock_sc` holds the value of `sc_lock` taken at the most recent strobe.
- R9: `lock_chg` is high for exactly the first cycle in which `lock_all` shows a new value, and is low at all other times.
- R10: In cycles without `line_stb`, the flags and counters do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One pulse per video line; qualifies all sampling |
| hlock_a | input | 1 | Raw horizontal lock, source 0 |
| hlock_b | input | 1 | Raw horizontal lock, source 1 |
| sc_lock | input | 1 | Raw subcarrier lock |
| src_sel | input | 1 | Picks the horizontal raw source |
| in_code | input | 3 | Code for the lines needed to gain lock |
| out_code | input | 3 | Code for the lines needed to lose lock |
| sc_incl | input | 1 | 1: overall lock also needs subcarrier lock |
| lock_all | output | 1 | Filtered overall lock |
| lock_h | output | 1 | Filtered horizontal lock |
| lock_sc | output | 1 | Subcarrier lock at the last strobe |
| lock_chg | output | 1 | One-cycle pulse when `lock_all` changes |

## Verification
Directed runs stop one line short of each threshold and then at the threshold itself. This separates an off-by-one count from a correct one. A single opposite line placed inside a run shows whether the run restarts or only pauses. Raw inputs are held against an idle strobe, and the unselected source toggles while the selected one stays low; both show whether sampling is properly gated. Long random runs change the source select, the thresholds and the subcarrier gating, and compare every output against a bench model. This tells the horizontal result apart from the overall result whenever the subcarrier lock is lost.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
  localparam int CODE_W = 3;
  localparam int unsigned MID_THR_MAX = 1000;

  // Lines needed for a transition, per 3-bit code.
  function automatic int unsigned lock_thr(input logic [CODE_W-1:0] code,
                                           input int unsigned long_thr);
    case (code)
      3'd0:    lock_thr = 1;
      3'd1:    lock_thr = 2;
      3'd2:    lock_thr = 5;
      3'd3:    lock_thr = 10;
      3'd4:    lock_thr = 100;
      3'd5:    lock_thr = 500;
      3'd6:    lock_thr = MID_THR_MAX;
      default: lock_thr = long_thr;
    endcase
  endfunction

  // Counter width able to hold the largest threshold.
  function automatic int cnt_width(input int unsigned long_thr);
    int unsigned top;
    top = (long_thr > MID_THR_MAX) ? long_thr : MID_THR_MAX;
    cnt_width = $clog2(top + 1);
  endfunction
endpackage

// File: rtl/vlock_sample.sv
module vlock_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic sel,
  input  logic raw_a,
  input  logic raw_b,
  input  logic sc,
  input  logic incl,
  output logic samp_h,
  output logic samp_o,
  output logic sc_flag
);
  logic sc_q;

  assign samp_h  = sel ? raw_b : raw_a;
  assign samp_o  = samp_h & (sc | ~incl);
  assign sc_flag = sc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sc_q <= 1'b0;
    else if (stb) sc_q <= sc;
  end
endmodule

// File: rtl/vlock_hyst.sv
module vlock_hyst
  import vlock_pkg::*;
#(
  parameter int unsigned LONG_THR = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              sample,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CODE_W-1:0] out_code,
  output logic              flag,
  output logic              flag_nxt
);
  localparam int CNT_W = cnt_width(LONG_THR);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, run_d, run_inc;
  logic             flag_q;
  int unsigned      thr;

  assign thr     = flag_q ? lock_thr(out_code, LONG_THR) : lock_thr(in_code, LONG_THR);
  assign run_inc = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;

  always_comb begin
    run_d    = run_q;
    flag_nxt = flag_q;
    if (stb) begin
      if (sample == flag_q) begin
        run_d = '0;
      end else if (32'(run_inc) >= thr) begin
        run_d    = '0;
        flag_nxt = ~flag_q;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_nxt;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/vlock_edge.sv
module vlock_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic nxt,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= cur ^ nxt;
  end
endmodule

// File: rtl/vlock_filter.sv
module vlock_filter
  import vlock_pkg::*;
#(
  parameter int unsigned LONG_THR = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              hlock_a,
  input  logic              hlock_b,
  input  logic              sc_lock,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CODE_W-1:0] out_code,
  input  logic              sc_incl,
  output logic              lock_all,
  output logic              lock_h,
  output logic              lock_sc,
  output logic              lock_chg
);
  localparam int NCH = 2;  // channel 0: horizontal, channel 1: overall

  logic samp_h, samp_o;
  logic [NCH-1:0] samp, flag, flag_nxt;

  vlock_sample u_samp (
    .clk(clk), .rst_n(rst_n), .stb(line_stb), .sel(src_sel),
    .raw_a(hlock_a), .raw_b(hlock_b), .sc(sc_lock), .incl(sc_incl),
    .samp_h(samp_h), .samp_o(samp_o), .sc_flag(lock_sc)
  );

  assign samp = {samp_o, samp_h};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    vlock_hyst #(.LONG_THR(LONG_THR)) u_hyst (
      .clk(clk), .rst_n(rst_n), .stb(line_stb), .sample(samp[g]),
      .in_code(in_code), .out_code(out_code),
      .flag(flag[g]), .flag_nxt(flag_nxt[g])
    );
  end

  vlock_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cur(flag[1]), .nxt(flag_nxt[1]), .pulse(lock_chg)
  );

  assign lock_h   = flag[0];
  assign lock_all = flag[1];
endmodule

// File: rtl/vlock_filter_chk.sv
module vlock_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic line_stb,
  input logic sc_lock,
  input logic sc_incl,
  input logic samp_h,
  input logic lock_all,
  input logic lock_h,
  input logic lock_sc,
  input logic lock_chg
);
  // R10
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(lock_h) && $stable(lock_all) && $stable(lock_sc));
  // R3
  rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_h) |-> $past(line_stb) && $past(samp_h));
  // R4
  fall_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_h) |-> $past(line_stb) && !$past(samp_h));
  // R7
  sc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && sc_incl && !sc_lock |=> !$rose(lock_all));
  // R8
  sc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> lock_sc == $past(sc_lock));
  // R9
  chg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_all != $past(lock_all)) |-> lock_chg);
  // R9
  chg_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_chg |-> (lock_all != $past(lock_all)));
endmodule

bind vlock_filter vlock_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .sc_lock(sc_lock),
  .sc_incl(sc_incl), .samp_h(samp_h), .lock_all(lock_all), .lock_h(lock_h),
  .lock_sc(lock_sc), .lock_chg(lock_chg)
);

// File: tb/tb_vlock_filter.sv
module tb_vlock_filter;
  localparam int unsigned LT = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, hlock_a = 1'b0, hlock_b = 1'b0, sc_lock = 1'b0;
  logic src_sel = 1'b0, sc_incl = 1'b0;
  logic [2:0] in_code = 3'd0, out_code = 3'd0;
  logic lock_all, lock_h, lock_sc, lock_chg;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_h, m_o, m_sc, m_chg;
  int unsigned r_h, r_o;

  always #10 clk = ~clk;

  vlock_filter #(.LONG_THR(LT)) dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .hlock_a(hlock_a),
    .hlock_b(hlock_b), .sc_lock(sc_lock), .src_sel(src_sel),
    .in_code(in_code), .out_code(out_code), .sc_incl(sc_incl),
    .lock_all(lock_all), .lock_h(lock_h), .lock_sc(lock_sc), .lock_chg(lock_chg)
  );

  function automatic int unsigned need(input logic [2:0] c);
    int unsigned t[8] = '{1, 2, 5, 10, 100, 500, 1000, LT};
    return t[c];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(inout bit lk, inout int unsigned run, input bit s);
    if (s == lk) run = 0;
    else begin
      run++;
      if (run >= need(lk ? out_code : in_code)) begin
        lk = s;
        run = 0;
      end
    end
  endtask

  task automatic step(input logic stb, input logic a, input logic b, input logic sc);
    bit sh, so, prev;
    @(negedge clk);
    line_stb = stb; hlock_a = a; hlock_b = b; sc_lock = sc;
    @(posedge clk);
    #1;
    prev = m_o;
    if (stb) begin
      sh = src_sel ? b : a;
      so = sh && (sc || !sc_incl);
      adv(m_h, r_h, sh);
      adv(m_o, r_o, so);
      m_sc = sc;
    end
    m_chg = (prev != m_o);
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " R3 R4 R5 lock_h"}, lock_h, m_h);
    chk({tag, " R6 R7 lock_all"}, lock_all, m_o);
    chk({tag, " R8 lock_sc"}, lock_sc, m_sc);
    chk({tag, " R9 lock_chg"}, lock_chg, m_chg);
  endtask

  task automatic reset_all();
    @(negedge clk);
    rst_n = 1'b0; line_stb = 0; hlock_a = 0; hlock_b = 0; sc_lock = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_h = 0; m_o = 0; m_sc = 0; m_chg = 0; r_h = 0; r_o = 0;
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    reset_all();
    #1;
    // R1 reset state
    chk("R1 lock_all", lock_all, 1'b0);
    chk("R1 lock_h", lock_h, 1'b0);
    chk("R1 lock_sc", lock_sc, 1'b0);
    chk("R1 lock_chg", lock_chg, 1'b0);

    // R3: threshold 5, four good lines keep it low, the fifth locks
    in_code = 3'd2; out_code = 3'd1; sc_incl = 0; src_sel = 0;
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1);
    chk("R3 below threshold", lock_h, 1'b0);
    step(1, 1, 0, 1);
    chk("R3 at threshold", lock_h, 1'b1);
    chk("R6 overall follows horizontal", lock_all, 1'b1);
    chk("R9 pulse on rise", lock_chg, 1'b1);
    step(0, 1, 0, 1);
    chk("R9 pulse one cycle", lock_chg, 1'b0);

    // R5: one bad line, then good, then one bad: still locked
    step(1, 0, 0, 1);
    step(1, 1, 0, 1);
    step(1, 0, 0, 1);
    chk("R5 run restarts", lock_h, 1'b1);
    // R4: second consecutive bad line unlocks
    step(1, 0, 0, 1);
    chk("R4 at threshold", lock_h, 1'b0);
    chk("R9 pulse on fall", lock_chg, 1'b1);

    // R10: raw high without strobe changes nothing
    in_code = 3'd0;
    for (int i = 0; i < 6; i++) step(0, 1, 1, 1);
    chk("R10 no strobe lock_h", lock_h, 1'b0);
    chk("R10 no strobe lock_sc", lock_sc, 1'b1);

    // R2: unselected source ignored
    step(1, 0, 0, 0);
    src_sel = 0;
    for (int i = 0; i < 6; i++) step(1, 0, 1, 1);
    chk("R2 source b ignored", lock_h, 1'b0);
    src_sel = 1;
    step(1, 0, 1, 1);
    chk("R2 source b selected", lock_h, 1'b1);
    out_code = 3'd0;
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1);
    chk("R2 source a ignored", lock_h, 1'b1);
    step(1, 1, 0, 1);
    chk("R2 unlock via b", lock_h, 1'b0);

    // R7: gating by subcarrier lock
    sc_incl = 1; src_sel = 0;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    chk("R7 horizontal locks", lock_h, 1'b1);
    chk("R7 overall gated", lock_all, 1'b0);
    step(1, 1, 0, 1);
    chk("R7 overall with sc", lock_all, 1'b1);
    // R6: without include, sc loss does not drop overall
    sc_incl = 0;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    chk("R6 sc ignored", lock_all, 1'b1);
    chk("R8 sc flag", lock_sc, 1'b0);

    // R3 long code 7 (LONG_THR)
    reset_all();
    in_code = 3'd7;
    for (int unsigned i = 0; i < LT - 1; i++) step(1, 1, 0, 1);
    chk("R3 long code below", lock_h, 1'b0);
    step(1, 1, 0, 1);
    chk("R3 long code at", lock_h, 1'b1);

    // random phase
    reset_all();
    begin
      logic a = 0, b = 0, sc = 0;
      for (int n = 0; n < 20000; n++) begin
        if (n % 400 == 0) begin
          in_code  = ($urandom % 8 == 0) ? 3'd4 : 3'($urandom % 4);
          out_code = ($urandom % 8 == 0) ? 3'd4 : 3'($urandom % 4);
          src_sel  = 1'($urandom);
          sc_incl  = 1'($urandom);
        end
        if ($urandom % 10 == 0) a = ~a;
        if ($urandom % 10 == 0) b = ~b;
        if ($urandom % 16 == 0) sc = ~sc;
        step(1'($urandom % 4 != 0), a, b, sc);
        if (n % 8 == 0) cmp_all("rand");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule